// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus that a target has left stuck, typically with SDA held low in the middle of a byte. When triggered, it takes both bus lines away from the normal I2C controller and drives them as open-drain outputs in a fixed pattern. The pattern releases both lines, forms a start condition, gives nine clock pulses with SDA released, and ends with a stop condition. Every edge of the pattern is held for a fixed step interval, counted in system clock cycles.

When the stop is complete, the block returns the pins to the controller and sends it a one-cycle reset. At the same moment it raises a one-cycle done strobe. Alongside that strobe it reports whether both lines read high. A combinational idle-level check is also provided, so that surrounding logic can decide whether a recovery is worth starting.

Top module: `i2c_recovery_seq`

## Requirements
- R1: After reset, busy, done and ctrlRst are 0, and the bus drive outputs follow the controller-side drive inputs.
- R2: While busy is 0, busSclOe equals ctlSclOe and busSdaOe equals ctlSdaOe. A drive output of 1 pulls the line low, and 0 releases it.
- R3: A startReq sampled high while idle makes busy 1 from the next cycle. For the first STEP_CYCLES cycles of the recovery, both lines are released.
- R4: The start condition comes next. SDA is pulled low with SCL released for STEP_CYCLES cycles. Then SCL is pulled low as well, for STEP_CYCLES cycles.
- R5: Exactly NUM_PULSES (default 9) clock pulses follow. Each pulse has SCL and SDA released for STEP_CYCLES cycles, then SCL pulled low with SDA released for STEP_CYCLES cycles.
- R6: The stop condition comes next. SDA is pulled low with SCL still low for STEP_CYCLES cycles, then SCL is released for STEP_CYCLES cycles, then SDA is released for STEP_CYCLES cycles.
- R7: In the cycle right after the stop phase, busy is 0, pin control is back with the controller, and both done and ctrlRst are 1 for exactly one cycle.
- R8: In the cycle where done is 1, linesIdle equals the logical AND of sclIn and sdaIn sampled at that edge. linesIdle keeps its value until the next done.
- R9: startReq has no effect while busy is 1. The pattern and its total length of (6 + 2*NUM_PULSES)*STEP_CYCLES cycles are unchanged.
- R10: needRecover is 1 exactly when ctrlBusy is 1, ctrlPend is 1, or sclIn and sdaIn are not both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Start a recovery (sampled while idle) |
| ctrlBusy | input | 1 | Controller reports a transfer in progress |
| ctrlPend | input | 1 | Controller has unacknowledged status |
| sclIn | input | 1 | Sampled SCL line level |
| sdaIn | input | 1 | Sampled SDA line level |
| ctlSclOe | input | 1 | Controller SCL pull-low request |
| ctlSdaOe | input | 1 | Controller SDA pull-low request |
| busSclOe | output | 1 | SCL pull-low drive to the pad |
| busSdaOe | output | 1 | SDA pull-low drive to the pad |
| ctrlRst | output | 1 | One-cycle reset to the controller |
| busy | output | 1 | Recovery in progress |
| done | output | 1 | One-cycle completion strobe |
| linesIdle | output | 1 | Both lines read high at completion |
| needRecover | output | 1 | Idle-level check result |

## Verification
The assertions check the following on every cycle:
- the controller drives pass through whenever the block is idle;
- both lines are released when busy rises;
- done coincides with the reset pulse and the fall of busy, and each lasts only one cycle;
- linesIdle holds between completions;
- a trigger during a recovery neither ends nor restarts it.

The exact edge timeline can only be shown by the bench scenarios. These cover the step-by-step pin pattern, the count of nine pulses and the total duration. They also cover the linesIdle result when a line stays stuck and when a modelled target releases SDA part-way through the pulses.

// File: rtl/i2c_rcv_pkg.sv
package i2c_rcv_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_REL, ST_STA_SDA, ST_STA_SCL, ST_CK_HI, ST_CK_LO,
    ST_SP_SDA, ST_SP_SCL, ST_SP_END
  } rcvState_t;

  typedef struct packed {
    logic take;
    logic finish;
    logic sclRel;
    logic sclLow;
    logic sdaRel;
    logic sdaLow;
  } rcvStrobes_t;
endpackage

// File: rtl/i2c_rcv_ctrl.sv
module i2c_rcv_ctrl
  import i2c_rcv_pkg::*;
#(
  parameter int STEP_CYCLES = 50000,
  parameter int NUM_PULSES  = 9
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  output logic        busy,
  output rcvStrobes_t strb
);
  localparam int CW = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam int PW = $clog2(NUM_PULSES + 1);
  localparam logic [CW-1:0] STEP_LAST = CW'(STEP_CYCLES - 1);
  localparam logic [PW-1:0] PULSE_LAST = PW'(NUM_PULSES - 1);

  rcvState_t state, nextState;
  logic [CW-1:0] stepCnt;
  logic [PW-1:0] pulseCnt;
  logic stepEnd;

  assign stepEnd = (stepCnt == STEP_LAST);
  assign busy = (state != ST_IDLE);

  always_comb begin
    nextState = state;
    strb = '0;
    case (state)
      ST_IDLE: if (startReq) begin
        nextState = ST_REL;
        strb.take = 1'b1; strb.sclRel = 1'b1; strb.sdaRel = 1'b1;
      end
      ST_REL: if (stepEnd) begin
        nextState = ST_STA_SDA; strb.sdaLow = 1'b1;
      end
      ST_STA_SDA: if (stepEnd) begin
        nextState = ST_STA_SCL; strb.sclLow = 1'b1;
      end
      ST_STA_SCL: if (stepEnd) begin
        nextState = ST_CK_HI; strb.sclRel = 1'b1; strb.sdaRel = 1'b1;
      end
      ST_CK_HI: if (stepEnd) begin
        nextState = ST_CK_LO; strb.sclLow = 1'b1;
      end
      ST_CK_LO: if (stepEnd) begin
        if (pulseCnt == PULSE_LAST) begin
          nextState = ST_SP_SDA; strb.sdaLow = 1'b1;
        end else begin
          nextState = ST_CK_HI; strb.sclRel = 1'b1; strb.sdaRel = 1'b1;
        end
      end
      ST_SP_SDA: if (stepEnd) begin
        nextState = ST_SP_SCL; strb.sclRel = 1'b1;
      end
      ST_SP_SCL: if (stepEnd) begin
        nextState = ST_SP_END; strb.sdaRel = 1'b1;
      end
      ST_SP_END: if (stepEnd) begin
        nextState = ST_IDLE; strb.finish = 1'b1;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      stepCnt  <= '0;
      pulseCnt <= '0;
    end else begin
      state <= nextState;
      if (state != nextState || state == ST_IDLE) stepCnt <= '0;
      else stepCnt <= stepCnt + 1'b1;
      if (state == ST_IDLE) pulseCnt <= '0;
      else if (state == ST_CK_LO && nextState == ST_CK_HI) pulseCnt <= pulseCnt + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_rcv_dp.sv
module i2c_rcv_dp
  import i2c_rcv_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  rcvStrobes_t strb,
  input  logic        ctrlBusy,
  input  logic        ctrlPend,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic        ctlSclOe,
  input  logic        ctlSdaOe,
  output logic        busSclOe,
  output logic        busSdaOe,
  output logic        ctrlRst,
  output logic        done,
  output logic        linesIdle,
  output logic        needRecover
);
  logic ownPins, sclLowReg, sdaLowReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownPins   <= 1'b0;
      sclLowReg <= 1'b0;
      sdaLowReg <= 1'b0;
      ctrlRst   <= 1'b0;
      done      <= 1'b0;
      linesIdle <= 1'b0;
    end else begin
      if (strb.take) ownPins <= 1'b1;
      else if (strb.finish) ownPins <= 1'b0;
      if (strb.sclLow) sclLowReg <= 1'b1;
      else if (strb.sclRel) sclLowReg <= 1'b0;
      if (strb.sdaLow) sdaLowReg <= 1'b1;
      else if (strb.sdaRel) sdaLowReg <= 1'b0;
      ctrlRst <= strb.finish;
      done    <= strb.finish;
      if (strb.finish) linesIdle <= sclIn & sdaIn;
    end
  end

  assign busSclOe = ownPins ? sclLowReg : ctlSclOe;
  assign busSdaOe = ownPins ? sdaLowReg : ctlSdaOe;
  assign needRecover = ctrlBusy | ctrlPend | ~(sclIn & sdaIn);
endmodule

// File: rtl/i2c_recovery_seq.sv
module i2c_recovery_seq
  import i2c_rcv_pkg::*;
#(
  parameter int STEP_CYCLES = 50000,
  parameter int NUM_PULSES  = 9
) (
  input  logic clk,
  input  logic rstN,
  input  logic startReq,
  input  logic ctrlBusy,
  input  logic ctrlPend,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic ctlSclOe,
  input  logic ctlSdaOe,
  output logic busSclOe,
  output logic busSdaOe,
  output logic ctrlRst,
  output logic busy,
  output logic done,
  output logic linesIdle,
  output logic needRecover
);
  rcvStrobes_t strb;

  i2c_rcv_ctrl #(.STEP_CYCLES(STEP_CYCLES), .NUM_PULSES(NUM_PULSES)) ctrl_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .busy(busy), .strb(strb)
  );

  i2c_rcv_dp dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .ctrlBusy(ctrlBusy), .ctrlPend(ctrlPend),
    .sclIn(sclIn), .sdaIn(sdaIn), .ctlSclOe(ctlSclOe), .ctlSdaOe(ctlSdaOe),
    .busSclOe(busSclOe), .busSdaOe(busSdaOe), .ctrlRst(ctrlRst), .done(done),
    .linesIdle(linesIdle), .needRecover(needRecover)
  );
endmodule

// File: rtl/i2c_rcv_chk.sv
module i2c_rcv_chk (
  input logic clk,
  input logic rstN,
  input logic startReq,
  input logic busy,
  input logic done,
  input logic ctrlRst,
  input logic busSclOe,
  input logic busSdaOe,
  input logic ctlSclOe,
  input logic ctlSdaOe,
  input logic linesIdle
);
  p_passthru_r2: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (busSclOe == ctlSclOe && busSdaOe == ctlSdaOe));

  p_release_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (!busSclOe && !busSdaOe));

  p_finish_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (ctrlRst && !busy && $past(busy)));

  p_one_cycle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (done || ctrlRst) |=> (!done && !ctrlRst));

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(linesIdle));

  p_ignore_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq && !done) |=> (busy || done));
endmodule

bind i2c_recovery_seq i2c_rcv_chk chk_i (
  .clk(clk), .rstN(rstN), .startReq(startReq), .busy(busy), .done(done),
  .ctrlRst(ctrlRst), .busSclOe(busSclOe), .busSdaOe(busSdaOe),
  .ctlSclOe(ctlSclOe), .ctlSdaOe(ctlSdaOe), .linesIdle(linesIdle)
);

// File: tb/i2c_recovery_seq_tb.sv
module i2c_recovery_seq_tb_top;
  localparam int STEP = 3;
  localparam int PULSES = 9;
  localparam int NSTEPS = 6 + 2 * PULSES;
  localparam int TOTAL = NSTEPS * STEP;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0, ctrlBusy = 1'b0, ctrlPend = 1'b0;
  logic ctlSclOe = 1'b0, ctlSdaOe = 1'b0;
  logic stuckScl = 1'b0, stuckSda = 1'b0;
  logic sclIn, sdaIn;
  logic busSclOe, busSdaOe, ctrlRst, busy, done, linesIdle, needRecover;
  int freeAfter = 0;
  int sclRises = 0;
  logic sclPrev = 1'b1;
  logic sdaFreed;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  assign sdaFreed = (freeAfter != 0) && (sclRises >= freeAfter);
  assign sclIn = ~(busSclOe | stuckScl);
  assign sdaIn = ~(busSdaOe | (stuckSda & ~sdaFreed));

  always @(posedge clk) begin
    sclPrev <= sclIn;
    if (!sclPrev && sclIn) sclRises <= sclRises + 1;
  end

  i2c_recovery_seq #(.STEP_CYCLES(STEP), .NUM_PULSES(PULSES)) dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .ctrlBusy(ctrlBusy),
    .ctrlPend(ctrlPend), .sclIn(sclIn), .sdaIn(sdaIn), .ctlSclOe(ctlSclOe),
    .ctlSdaOe(ctlSdaOe), .busSclOe(busSclOe), .busSdaOe(busSdaOe),
    .ctrlRst(ctrlRst), .busy(busy), .done(done), .linesIdle(linesIdle),
    .needRecover(needRecover)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected pull-low drive per step index: {scl, sda}
  function automatic logic [1:0] expDrive(input int s);
    if (s == 0) return 2'b00;
    if (s == 1) return 2'b01;
    if (s == 2) return 2'b11;
    if (s < 3 + 2 * PULSES) return (((s - 3) % 2) == 0) ? 2'b00 : 2'b10;
    if (s == 3 + 2 * PULSES) return 2'b11;
    if (s == 4 + 2 * PULSES) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic expNeed(input logic b, input logic p, input logic c, input logic d);
    return b || p || !(c && d);
  endfunction

  task automatic runRecovery(input logic holdTrig, input logic expIdle, input string tag);
    int errR3 = 0, errR4 = 0, errR5 = 0, errR6 = 0, errBusy = 0;
    @(negedge clk);
    startReq = 1'b1;
    sclRises = 0;
    for (int i = 0; i < TOTAL; i++) begin
      @(posedge clk);
      @(negedge clk);
      startReq = holdTrig && (i < TOTAL - 2);
      ctlSclOe = $urandom_range(0, 1);
      ctlSdaOe = $urandom_range(0, 1);
      if (!busy || done) errBusy++;
      if ({busSclOe, busSdaOe} !== expDrive(i / STEP)) begin
        if (i / STEP == 0) errR3++;
        else if (i / STEP < 3) errR4++;
        else if (i / STEP < 3 + 2 * PULSES) errR5++;
        else errR6++;
      end
    end
    check({"R3 release phase ", tag}, errR3, 0);
    check({"R4 start phase ", tag}, errR4, 0);
    check({"R5 nine pulses ", tag}, errR5, 0);
    check({"R6 stop phase ", tag}, errR6, 0);
    check({"R9 busy through recovery ", tag}, errBusy, 0);
    @(posedge clk);
    @(negedge clk);
    check({"R7 done/rst/busy ", tag}, {done, ctrlRst, busy}, 3'b110);
    check({"R7 pins returned ", tag}, {busSclOe, busSdaOe}, {ctlSclOe, ctlSdaOe});
    check({"R8 linesIdle ", tag}, linesIdle, expIdle);
    @(posedge clk);
    @(negedge clk);
    check({"R7 single pulse ", tag}, {done, ctrlRst, busy}, 3'b000);
    check({"R8 linesIdle held ", tag}, linesIdle, expIdle);
  endtask

  initial begin
    #(20 * 20000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset outputs", {busy, done, ctrlRst}, 3'b000);
    rstN = 1'b1;
    ctlSclOe = 1'b1;
    ctlSdaOe = 1'b0;
    @(negedge clk);
    check("R1 pins follow controller", {busSclOe, busSdaOe}, 2'b10);

    // random idle traffic: passthrough and idle-level check
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      ctlSclOe = $urandom_range(0, 1);
      ctlSdaOe = $urandom_range(0, 1);
      ctrlBusy = $urandom_range(0, 1);
      ctrlPend = $urandom_range(0, 1);
      stuckScl = ($urandom_range(0, 3) == 0);
      stuckSda = ($urandom_range(0, 3) == 0);
      #1;
      check("R2 passthrough", {busSclOe, busSdaOe}, {ctlSclOe, ctlSdaOe});
      check("R10 needRecover", needRecover, expNeed(ctrlBusy, ctrlPend, sclIn, sdaIn));
      check("R2 stays idle", busy, 1'b0);
    end
    @(negedge clk);
    ctrlBusy = 1'b0; ctrlPend = 1'b0; stuckScl = 1'b0; stuckSda = 1'b0;
    ctlSclOe = 1'b0; ctlSdaOe = 1'b0;
    #1;
    check("R10 clean bus", needRecover, 1'b0);

    runRecovery(1'b0, 1'b1, "clean");
    stuckSda = 1'b1; freeAfter = 0;
    runRecovery(1'b0, 1'b0, "sda stuck");
    freeAfter = 4;
    runRecovery(1'b0, 1'b1, "sda freed by pulses");
    stuckSda = 1'b0; freeAfter = 0;
    stuckScl = 1'b1;
    runRecovery(1'b1, 1'b0, "scl stuck, trigger held R9");
    stuckScl = 1'b0;
    runRecovery(1'b1, 1'b1, "trigger held R9");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule